// File: doc/BRIEF.md
# Cache Type Register Write Checker

This block holds the cache-type configuration state of one processor context. That state is a page attribute register, a default-type register with enable bits, eleven fixed-range registers and eight variable-range base/mask pairs. Each write arrives as a strobe with a 6-bit address and 64 bits of data. The block checks the data against the encoding rules of the register class it targets.

In the same cycle the block answers with either an accept or a reject pulse. An accepted write commits on the next rising clock edge. A rejected write leaves every register as it was. A combinational read port returns any register, including a read-only capability word.

The physical address width is a parameter and defaults to 36. It decides which high bits of the variable-range registers are reserved.

Top module: `cache_attr_regs`

## Requirements
- R1: After reset the registers read back as follows. The page attribute register reads 0x0007040600070406. The default-type register, all fixed-range registers and all variable registers read 0. The capability word reads 0x508 (8 variable ranges in bits 7:0, plus bits 8 and 10 set).
- R2: A write to the page attribute register (address 0x00) is accepted only if every one of its eight bytes is 0, 1, 4, 5, 6 or 7.
- R3: A write to the default-type register (address 0x01) is accepted only if two conditions hold. Bits 7:0 must be 0, 1, 4, 5 or 6. No bit outside mask 0xCFF may be set. The enable bits 11:10 are stored and read back.
- R4: A write to fixed-range register i (address 0x10+i, i from 0 to 10) is accepted only if every byte is 0, 1, 4, 5 or 6.
- R5: A write to variable base i (address 0x20+2i) is accepted only if three conditions hold. Bits 7:0 must be 0, 1, 4, 5 or 6. Bits 11:8 must be zero. Every bit at or above the physical address width must be zero.
- R6: A write to variable mask i (address 0x21+2i) is accepted only if bits 10:0 and every bit at or above the physical address width are zero. Bit 11, the valid bit, may take either value.
- R7: With the strobe high, exactly one of wr_ok and wr_err is high in that same cycle. With the strobe low, both are low. An accepted write is visible on the read port after the next rising edge. A rejected write changes no register.
- R8: Writing a register's current value is always accepted and leaves the value unchanged.
- R9: The capability word (address 0x02) is read-only. Any write to it is rejected, and so is any write to an address outside the map.
- R10: Reads of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 6 | Write register address |
| wr_data | input | 64 | Write data |
| wr_ok | output | 1 | Write accepted (same cycle) |
| wr_err | output | 1 | Write rejected (same cycle) |
| rd_addr | input | 6 | Read register address |
| rd_data | output | 64 | Read data (combinational) |

## Verification
Every byte lane of the page attribute and fixed-range registers is swept through all 256 values. This catches a design that tests only the low byte, or that admits the reserved codes 2 and 3, or that rejects code 7 in the page attribute register (or admits it in a fixed register). A single set bit is walked across all 64 positions of the default, base and mask registers, which exposes a reserved mask that is off by one at bit 11:8, at 10:0, or at the address-width boundary. After each write the bench reads the register back. A design that commits a rejected write, or drops an accepted one, shows up there. Rewrites of current values, writes to the capability word and writes to holes in the map show whether the block wrongly accepts or wrongly alters state.

// File: rtl/cache_attr_regs.sv
module cache_attr_regs #(
  parameter int PA_BITS = 36,
  parameter int NVAR    = 8,
  parameter int NFIX    = 11
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [5:0]  wr_addr,
  input  logic [63:0] wr_data,
  output logic        wr_ok,
  output logic        wr_err,
  input  logic [5:0]  rd_addr,
  output logic [63:0] rd_data
);

  localparam logic [63:0] HI_RES  = ~((64'd1 << PA_BITS) - 64'd1);
  localparam logic [63:0] CAP_VAL = 64'h500 | 64'(NVAR);
  localparam logic [63:0] PAR_RST = 64'h0007040600070406;
  localparam logic [63:0] DEF_KEEP = 64'h0000_0000_0000_0CFF;
  localparam int NVREG = 2 * NVAR;

  localparam logic [2:0] C_NONE = 3'd0, C_PAR = 3'd1, C_DEF = 3'd2, C_CAP = 3'd3,
                         C_FIX = 3'd4, C_VB = 3'd5, C_VM = 3'd6;

  function automatic logic type_ok(input logic [7:0] t);
    return (t == 8'd0) || (t == 8'd1) || (t == 8'd4) || (t == 8'd5) || (t == 8'd6);
  endfunction

  function automatic logic bytes_ok(input logic [63:0] d, input logic allow7);
    logic r;
    r = 1'b1;
    for (int b = 0; b < 8; b++)
      if (!(type_ok(d[8*b +: 8]) || (allow7 && d[8*b +: 8] == 8'd7))) r = 1'b0;
    return r;
  endfunction

  function automatic logic [2:0] cls_of(input logic [5:0] a);
    if (a == 6'h00) return C_PAR;
    if (a == 6'h01) return C_DEF;
    if (a == 6'h02) return C_CAP;
    if (a[5:4] == 2'b01 && int'(a[3:0]) < NFIX) return C_FIX;
    if (a[5:4] == 2'b10 && int'(a[3:0]) < NVREG) return a[0] ? C_VM : C_VB;
    return C_NONE;
  endfunction

  logic [63:0] par_q, def_q;
  logic [63:0] fix_q [NFIX];
  logic [63:0] var_q [NVREG];

  logic [5:0]  pa [2];
  logic [63:0] pv [2];
  assign pa[0] = rd_addr;
  assign pa[1] = wr_addr;

  for (genvar p = 0; p < 2; p++) begin : g_port
    always_comb begin
      pv[p] = '0;
      case (cls_of(pa[p]))
        C_PAR:   pv[p] = par_q;
        C_DEF:   pv[p] = def_q;
        C_CAP:   pv[p] = CAP_VAL;
        C_FIX:   pv[p] = fix_q[pa[p][3:0]];
        C_VB,
        C_VM:    pv[p] = var_q[pa[p][3:0]];
        default: pv[p] = '0;
      endcase
    end
  end

  assign rd_data = pv[0];

  logic [2:0] wcls;
  logic       legal;
  assign wcls = cls_of(wr_addr);

  always_comb begin
    case (wcls)
      C_PAR:   legal = bytes_ok(wr_data, 1'b1);
      C_DEF:   legal = type_ok(wr_data[7:0]) && ((wr_data & ~DEF_KEEP) == '0);
      C_FIX:   legal = bytes_ok(wr_data, 1'b0);
      C_VB:    legal = type_ok(wr_data[7:0]) && (wr_data[11:8] == 4'd0) && ((wr_data & HI_RES) == '0);
      C_VM:    legal = (wr_data[10:0] == 11'd0) && ((wr_data & HI_RES) == '0);
      default: legal = 1'b0;
    endcase
    if (wcls != C_NONE && wcls != C_CAP && wr_data == pv[1]) legal = 1'b1;
  end

  assign wr_ok  = wr_en & legal;
  assign wr_err = wr_en & ~legal;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      par_q <= PAR_RST;
      def_q <= '0;
      for (int i = 0; i < NFIX; i++) fix_q[i] <= '0;
      for (int i = 0; i < NVREG; i++) var_q[i] <= '0;
    end else if (wr_ok) begin
      case (wcls)
        C_PAR:   par_q <= wr_data;
        C_DEF:   def_q <= wr_data;
        C_FIX:   fix_q[wr_addr[3:0]] <= wr_data;
        C_VB,
        C_VM:    var_q[wr_addr[3:0]] <= wr_data;
        default: ;
      endcase
    end
  end

  a_r7_one_resp: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_ok != wr_err));
  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |-> (!wr_ok && !wr_err));
  a_r7_reject_holds: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |=> (par_q == $past(par_q) && def_q == $past(def_q)));
  a_r7_par_commit: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && wr_addr == 6'h00) |=> (par_q == $past(wr_data)));
  a_r2_par_legal: assert property (@(posedge clk) disable iff (!rst_n)
    bytes_ok(par_q, 1'b1));
  a_r3_def_legal: assert property (@(posedge clk) disable iff (!rst_n)
    type_ok(def_q[7:0]) && ((def_q & ~DEF_KEEP) == '0));

  for (genvar v = 0; v < NVAR; v++) begin : g_chk
    a_r6_mask_low_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (var_q[2*v+1][10:0] == 11'd0) && ((var_q[2*v+1] & HI_RES) == '0));
    a_r5_base_res_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (var_q[2*v][11:8] == 4'd0) && type_ok(var_q[2*v][7:0]));
  end

endmodule

// File: tb/test_cache_attr_regs.sv
`timescale 1ns/1ps
module test_cache_attr_regs;
  localparam int PA = 36;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [5:0]  wr_addr = '0;
  logic [63:0] wr_data = '0;
  logic        wr_ok, wr_err;
  logic [5:0]  rd_addr = '0;
  logic [63:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [63:0] mdl [64];

  always #2 clk = ~clk;

  cache_attr_regs #(.PA_BITS(PA), .NVAR(8), .NFIX(11)) i_cache_attr_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_ok(wr_ok), .wr_err(wr_err), .rd_addr(rd_addr), .rd_data(rd_data));

  task automatic check(input bit cond, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic bit t_ok(input int v);
    return v == 0 || v == 1 || (v >= 4 && v <= 6);
  endfunction

  function automatic bit exp_legal(input int a, input logic [63:0] d);
    bit ok;
    logic [63:0] hi;
    hi = ~((64'd1 << PA) - 64'd1);
    ok = 1'b0;
    if (a == 0) begin
      ok = 1'b1;
      for (int b = 0; b < 8; b++) if (!(t_ok(int'(d[8*b +: 8])) || d[8*b +: 8] == 8'd7)) ok = 1'b0;
    end else if (a == 1) begin
      ok = t_ok(int'(d[7:0])) && ((d & ~64'hCFF) == 64'd0);
    end else if (a >= 16 && a < 27) begin
      ok = 1'b1;
      for (int b = 0; b < 8; b++) if (!t_ok(int'(d[8*b +: 8]))) ok = 1'b0;
    end else if (a >= 32 && a < 48 && a % 2 == 0) begin
      ok = t_ok(int'(d[7:0])) && d[11:8] == 4'd0 && (d & hi) == 64'd0;
    end else if (a >= 32 && a < 48) begin
      ok = d[10:0] == 11'd0 && (d & hi) == 64'd0;
    end
    if (a != 2 && (a < 3 || (a >= 16 && a < 27) || (a >= 32 && a < 48)) && d == mdl[a]) ok = 1'b1;
    return ok;
  endfunction

  task automatic wr_chk(input int a, input logic [63:0] d, input string req);
    bit e;
    e = exp_legal(a, d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 6'(a); wr_data = d;
    #1;
    check(wr_ok == e && wr_err == !e, req, {62'd0, wr_ok, wr_err}, {62'd0, e, !e});
    @(negedge clk);
    if (e) mdl[a] = d;
    wr_en = 1'b0; rd_addr = 6'(a);
    #1;
    check(rd_data == mdl[a], req, rd_data, mdl[a]);
  endtask

  initial begin
    #760000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) mdl[i] = 64'd0;
    mdl[0] = 64'h0007040600070406;
    mdl[2] = 64'h508;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values, R10 unmapped reads zero
    for (int a = 0; a < 64; a++) begin
      @(negedge clk); rd_addr = 6'(a); #1;
      check(rd_data == mdl[a], "R1/R10 reset read", rd_data, mdl[a]);
    end

    // R7 idle: no response
    @(negedge clk); wr_en = 1'b0; wr_addr = 6'h00; wr_data = 64'hFF; #1;
    check(!wr_ok && !wr_err, "R7 idle", {62'd0, wr_ok, wr_err}, 64'd0);

    // R2 page attribute byte sweep
    for (int b = 0; b < 8; b++)
      for (int v = 0; v < 256; v++) begin
        logic [63:0] d;
        d = mdl[0];
        d[8*b +: 8] = 8'(v);
        wr_chk(0, d, "R2 par byte");
      end

    // R4 fixed-range byte sweep
    for (int r = 0; r < 11; r++)
      for (int b = 0; b < 8; b++)
        for (int v = 0; v < 256; v++) begin
          logic [63:0] d;
          d = mdl[16 + r];
          d[8*b +: 8] = 8'(v);
          wr_chk(16 + r, d, "R4 fixed byte");
        end

    // R3 default type sweep and reserved bit walk
    for (int v = 0; v < 256; v++) wr_chk(1, 64'hC00 | 64'(v), "R3 def type");
    for (int bit_i = 0; bit_i < 64; bit_i++) wr_chk(1, 64'd6 | (64'd1 << bit_i), "R3 def reserved");

    // R5 variable base: type sweep and bit walk
    for (int v = 0; v < 256; v++) wr_chk(32, 64'h1000 | 64'(v), "R5 base type");
    for (int i = 0; i < 8; i++)
      for (int bit_i = 0; bit_i < 64; bit_i++) wr_chk(32 + 2*i, 64'd6 | (64'd1 << bit_i), "R5 base bits");

    // R6 variable mask bit walk
    for (int i = 0; i < 8; i++)
      for (int bit_i = 0; bit_i < 64; bit_i++) wr_chk(33 + 2*i, 64'h800 | (64'd1 << bit_i), "R6 mask bits");
    wr_chk(33, 64'h0000_000F_FFFF_F800, "R6 mask full");

    // R8 rewrite current value of every mapped register
    for (int a = 0; a < 48; a++)
      if (a < 2 || (a >= 16 && a < 27) || a >= 32) wr_chk(a, mdl[a], "R8 rewrite");

    // R9 capability and holes are not writable
    wr_chk(2, 64'h508, "R9 cap same");
    wr_chk(2, 64'h0, "R9 cap zero");
    wr_chk(3, 64'h0, "R9 hole");
    wr_chk(27, 64'h0, "R9 fixed hole");
    wr_chk(48, 64'h0, "R9 var hole");
    wr_chk(63, 64'h6, "R9 top hole");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule